// File: doc/BRIEF.md
# Round-Robin Multi-Context Accumulator Processor

This block runs several independent small programs on one shared execution slot. Each program context keeps its own program counter, its own 18-bit accumulator, a halted flag and a private bank of 12-bit words. Each clock cycle in which `run` is high, the slot serves the next context in a fixed rotation and executes one instruction for it. Every context therefore advances by exactly one instruction per full turn. A halted context still uses its turn, so the rate of every other context never depends on which programs have stopped.

While `run` is low, a debug port preloads the banks and reads them back. The same port may also write while the contexts run. Each slot produces a trace record one clock later: which context was served, the address of the instruction, the accumulator after it, and whether an instruction actually ran. The number of contexts is a build parameter, meant to be 10, 14, 17 or 20. The bank size is a parameter too: `MEM_AW` = 12 gives 4096 words per context, and the default is smaller to keep elaboration light.

Top module: `bsp_barrel`

## Requirements
- R1: While `run` is high, the served context steps 0, 1, …, N_CTX−1 and then back to 0, one context per clock. Each trace record names the context that was served in the previous cycle.
- R2: While `run` is low, no slot is consumed. The rotation position, every program counter and every accumulator hold their values, and `tr_valid` is low one clock later.
- R3: Reset clears every program counter, accumulator and halted flag, and `tr_valid`. The first slot after reset serves context 0 at address 0.
- R4: An instruction word carries its opcode in bits 11:6 and its operand in bits 5:0. The operand is either an immediate value or a direct address among words 0–63. Opcodes: 0x00 halt, 0x01 load immediate, 0x02 load from address, 0x03 add immediate, 0x04 add from address, 0x05 store, 0x06 branch if zero. Every instruction except halt and a taken branch moves the program counter to the next word, wrapping at the top of the bank.
- R5: Both loads replace the accumulator with the zero-extended 6-bit immediate or the zero-extended 12-bit word.
- R6: Both adds sum the accumulator and the zero-extended operand modulo 2^18.
- R7: A store writes the low 12 bits of the accumulator into the addressed word of the executing context's own bank and no other bank. It leaves the accumulator unchanged.
- R8: Branch-if-zero loads the program counter with the operand when the accumulator is zero. Otherwise the program counter moves to the next word.
- R9: Halt sets the context's halted flag and leaves its program counter on the halt word. From then on, the context's turns produce trace records with `tr_exec` low and unchanged state, and the timing of the other contexts does not change.
- R10: With `dbg_we` high, `dbg_wdata` is written into word `dbg_addr` of context `dbg_ctx` at the clock edge. `dbg_rdata` shows that word combinationally. If a store hits the same word at the same edge, the debug write wins.
- R11: Any opcode other than those listed in R4 only moves the program counter to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Advance the rotation and execute this cycle |
| dbg_we | input | 1 | Debug write strobe |
| dbg_ctx | input | $clog2(N_CTX) | Debug context select |
| dbg_addr | input | MEM_AW | Debug word address |
| dbg_wdata | input | 12 | Debug write data |
| dbg_rdata | output | 12 | Debug read data, combinational |
| tr_valid | output | 1 | A slot was consumed in the previous cycle |
| tr_exec | output | 1 | That slot executed an instruction (context not halted) |
| tr_ctx | output | $clog2(N_CTX) | Context served in that slot |
| tr_pc | output | MEM_AW | Address of the instruction in that slot |
| tr_acc | output | 18 | Accumulator of that context after the slot |

## Verification
A slot taken in cycle k shows up on the trace outputs after the rising edge that ends cycle k, so exactly one register stage lies between stimulus and result. The bench drives `run` and the debug inputs at the falling edge. It steps its behavioural model once for that cycle and compares the trace 1 ns after the next rising edge. Stores and debug writes land at that same edge. Memory contents are therefore checked through `dbg_rdata` with `run` low, in the same cycle the address is applied, because that path has no register.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int WORD_W = 12;
    localparam int ACC_W  = 18;
    localparam int OPC_W  = 6;
    localparam int OPD_W  = 6;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT = 6'h00,
        OP_LDI  = 6'h01,
        OP_LDM  = 6'h02,
        OP_ADI  = 6'h03,
        OP_ADM  = 6'h04,
        OP_STM  = 6'h05,
        OP_BZ   = 6'h06
    } opcode_e;
endpackage

// File: rtl/bsp_rotor.sv
module bsp_rotor #(
    parameter int N_CTX = 10,
    localparam int CW = $clog2(N_CTX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] slot
);
    localparam logic [CW-1:0] LAST = CW'(N_CTX - 1);

    typedef struct packed {
        logic [CW-1:0] slot;
    } rot_t;

    rot_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (adv) begin
            r_d.slot = (r_q.slot == LAST) ? '0 : r_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign slot = r_q.slot;
endmodule

// File: rtl/bsp_ctx_mem.sv
module bsp_ctx_mem #(
    parameter int N_CTX  = 10,
    parameter int MEM_AW = 6,
    localparam int CW    = $clog2(N_CTX),
    localparam int SLOTS = 2 ** CW,
    localparam int DEPTH = 2 ** MEM_AW
) (
    input  logic              clk,
    input  logic [CW-1:0]     if_ctx,
    input  logic [MEM_AW-1:0] if_addr,
    output logic [11:0]       if_word,
    input  logic [CW-1:0]     op_ctx,
    input  logic [MEM_AW-1:0] op_addr,
    output logic [11:0]       op_word,
    input  logic [CW-1:0]     rd_ctx,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [11:0]       rd_word,
    input  logic              st_we,
    input  logic [CW-1:0]     st_ctx,
    input  logic [MEM_AW-1:0] st_addr,
    input  logic [11:0]       st_data,
    input  logic              wr_we,
    input  logic [CW-1:0]     wr_ctx,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [11:0]       wr_data
);
    logic [11:0] if_b [SLOTS];
    logic [11:0] op_b [SLOTS];
    logic [11:0] rd_b [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_bank
        if (g < N_CTX) begin : g_real
            logic [11:0] cells [DEPTH];
            always_ff @(posedge clk) begin
                if (st_we && st_ctx == CW'(g)) cells[st_addr] <= st_data;
                // later assignment wins on a same-word collision
                if (wr_we && wr_ctx == CW'(g)) cells[wr_addr] <= wr_data;
            end
            assign if_b[g] = cells[if_addr];
            assign op_b[g] = cells[op_addr];
            assign rd_b[g] = cells[rd_addr];
        end else begin : g_pad
            assign if_b[g] = '0;
            assign op_b[g] = '0;
            assign rd_b[g] = '0;
        end
    end

    assign if_word = if_b[if_ctx];
    assign op_word = op_b[op_ctx];
    assign rd_word = rd_b[rd_ctx];
endmodule

// File: rtl/bsp_exec.sv
module bsp_exec
    import bsp_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [ACC_W-1:0]  acc,
    input  logic [MEM_AW-1:0] pc,
    input  logic [WORD_W-1:0] opnd,
    output logic [ACC_W-1:0]  acc_n,
    output logic [MEM_AW-1:0] pc_n,
    output logic              halt,
    output logic              st_we
);
    logic [OPD_W-1:0]  imm;
    logic [MEM_AW-1:0] pc_inc;

    assign imm    = instr[OPD_W-1:0];
    assign pc_inc = pc + 1'b1;

    always_comb begin
        acc_n = acc;
        pc_n  = pc_inc;
        halt  = 1'b0;
        st_we = 1'b0;
        case (opcode_e'(instr[WORD_W-1:OPD_W]))
            OP_HALT: begin
                halt = 1'b1;
                pc_n = pc;
            end
            OP_LDI: acc_n = ACC_W'(imm);
            OP_LDM: acc_n = ACC_W'(opnd);
            OP_ADI: acc_n = acc + ACC_W'(imm);
            OP_ADM: acc_n = acc + ACC_W'(opnd);
            OP_STM: st_we = 1'b1;
            OP_BZ:  if (acc == '0) pc_n = MEM_AW'(imm);
            default: ;
        endcase
    end
endmodule

// File: rtl/bsp_barrel.sv
module bsp_barrel
    import bsp_pkg::*;
#(
    parameter int N_CTX  = 10,
    parameter int MEM_AW = 6,
    localparam int CW    = $clog2(N_CTX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              dbg_we,
    input  logic [CW-1:0]     dbg_ctx,
    input  logic [MEM_AW-1:0] dbg_addr,
    input  logic [11:0]       dbg_wdata,
    output logic [11:0]       dbg_rdata,
    output logic              tr_valid,
    output logic              tr_exec,
    output logic [CW-1:0]     tr_ctx,
    output logic [MEM_AW-1:0] tr_pc,
    output logic [17:0]       tr_acc
);
    typedef struct packed {
        logic [N_CTX-1:0][MEM_AW-1:0] pc;
        logic [N_CTX-1:0][ACC_W-1:0]  acc;
        logic [N_CTX-1:0]             halted;
        logic                         tv;
        logic                         te;
        logic [CW-1:0]                tc;
        logic [MEM_AW-1:0]            tp;
        logic [ACC_W-1:0]             ta;
    } state_t;

    state_t s_d, s_q;

    logic [CW-1:0]     slot_ctx;
    logic [WORD_W-1:0] cur_instr;
    logic [WORD_W-1:0] cur_opnd;
    logic [ACC_W-1:0]  ex_acc;
    logic [MEM_AW-1:0] ex_pc;
    logic              ex_halt;
    logic              ex_st;
    logic              do_exec;
    logic              mem_st;

    bsp_rotor #(.N_CTX(N_CTX)) u_rotor (
        .clk  (clk),
        .rst  (rst),
        .adv  (run),
        .slot (slot_ctx)
    );

    bsp_ctx_mem #(.N_CTX(N_CTX), .MEM_AW(MEM_AW)) u_mem (
        .clk     (clk),
        .if_ctx  (slot_ctx),
        .if_addr (s_q.pc[slot_ctx]),
        .if_word (cur_instr),
        .op_ctx  (slot_ctx),
        .op_addr (MEM_AW'(cur_instr[OPD_W-1:0])),
        .op_word (cur_opnd),
        .rd_ctx  (dbg_ctx),
        .rd_addr (dbg_addr),
        .rd_word (dbg_rdata),
        .st_we   (mem_st),
        .st_ctx  (slot_ctx),
        .st_addr (MEM_AW'(cur_instr[OPD_W-1:0])),
        .st_data (s_q.acc[slot_ctx][WORD_W-1:0]),
        .wr_we   (dbg_we),
        .wr_ctx  (dbg_ctx),
        .wr_addr (dbg_addr),
        .wr_data (dbg_wdata)
    );

    bsp_exec #(.MEM_AW(MEM_AW)) u_exec (
        .instr (cur_instr),
        .acc   (s_q.acc[slot_ctx]),
        .pc    (s_q.pc[slot_ctx]),
        .opnd  (cur_opnd),
        .acc_n (ex_acc),
        .pc_n  (ex_pc),
        .halt  (ex_halt),
        .st_we (ex_st)
    );

    assign do_exec = run && !s_q.halted[slot_ctx];
    assign mem_st  = do_exec && ex_st;

    always_comb begin
        s_d    = s_q;
        s_d.tv = 1'b0;
        s_d.te = 1'b0;
        if (run) begin
            s_d.tv = 1'b1;
            s_d.tc = slot_ctx;
            s_d.tp = s_q.pc[slot_ctx];
            s_d.ta = s_q.acc[slot_ctx];
            if (do_exec) begin
                s_d.te               = 1'b1;
                s_d.pc[slot_ctx]     = ex_pc;
                s_d.acc[slot_ctx]    = ex_acc;
                s_d.halted[slot_ctx] = ex_halt;
                s_d.ta               = ex_acc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign tr_valid = s_q.tv;
    assign tr_exec  = s_q.te;
    assign tr_ctx   = s_q.tc;
    assign tr_pc    = s_q.tp;
    assign tr_acc   = s_q.ta;
endmodule

// File: rtl/bsp_barrel_chk.sv
module bsp_barrel_chk #(
    parameter int N_CTX = 10,
    localparam int CW   = $clog2(N_CTX)
) (
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic [CW-1:0] slot,
    input logic          tr_valid,
    input logic          tr_exec,
    input logic [CW-1:0] tr_ctx
);
    localparam logic [CW-1:0] LAST = CW'(N_CTX - 1);

    assert_rotate_R1: assert property (@(posedge clk) disable iff (rst)
        run |=> slot == (($past(slot) == LAST) ? '0 : CW'($past(slot) + 1'b1)));

    assert_trace_ctx_R1: assert property (@(posedge clk) disable iff (rst)
        run |=> (tr_valid && tr_ctx == $past(slot)));

    assert_freeze_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(slot) && !tr_valid));

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot == '0 && !tr_valid));

    assert_exec_in_slot_R9: assert property (@(posedge clk) disable iff (rst)
        tr_exec |-> tr_valid);
endmodule

bind bsp_barrel bsp_barrel_chk #(.N_CTX(N_CTX)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .slot     (slot_ctx),
    .tr_valid (tr_valid),
    .tr_exec  (tr_exec),
    .tr_ctx   (tr_ctx)
);

// File: tb/bsp_barrel_bench.sv
`timescale 1ns/1ps
module bsp_barrel_bench;
    localparam int N     = 10;
    localparam int AW    = 6;
    localparam int CW    = $clog2(N);
    localparam int DEPTH = 2 ** AW;
    localparam int AMASK = (1 << 18) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic          dbg_we = 1'b0;
    logic [CW-1:0] dbg_ctx = '0;
    logic [AW-1:0] dbg_addr = '0;
    logic [11:0]   dbg_wdata = '0;
    logic [11:0]   dbg_rdata;
    logic          tr_valid, tr_exec;
    logic [CW-1:0] tr_ctx;
    logic [AW-1:0] tr_pc;
    logic [17:0]   tr_acc;

    bsp_barrel #(.N_CTX(N), .MEM_AW(AW)) u_bsp_barrel (
        .clk(clk), .rst(rst), .run(run),
        .dbg_we(dbg_we), .dbg_ctx(dbg_ctx), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .tr_valid(tr_valid), .tr_exec(tr_exec), .tr_ctx(tr_ctx),
        .tr_pc(tr_pc), .tr_acc(tr_acc)
    );

    always #2 clk = ~clk;

    int total = 0;
    int fails = 0;

    // behavioural model
    int mm [N][DEPTH];
    int mpc [N];
    int macc [N];
    bit mh [N];
    int mrot;
    bit e_valid, e_exec;
    int e_ctx, e_pc, e_acc;
    string pc_tag, acc_tag;

    task automatic chk(string tag, int act, int exp, string what);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int w(int op, int opd);
        return op * 64 + opd;
    endfunction

    function automatic int prog(int c, int a);
        case (c)
            0: return (a == 63) ? 12'hFFF : w(4, 63);  // adds, then undefined op 0x3F
            1: case (a)
                   0: return w(1, 5);  1: return w(5, 50); 2: return w(2, 50);
                   3: return w(3, 1);  4: return w(5, 50); 5: return w(1, 0);
                   6: return w(6, 2);  default: return 0;
               endcase
            2: case (a)
                   0: return w(1, 3);  1: return w(6, 0); 2: return w(3, 63);
                   default: return 0;
               endcase
            3: case (a)
                   0: return w(1, 7);  1: return w(5, 20);
                   default: return 0;
               endcase
            4: case (a)
                   0: return w(1, 9);  1: return w(5, 50);
                   default: return 0;
               endcase
            5: case (a)
                   0: return w(1, 1);  1: return w(3, 2);  2: return w(5, 20);
                   3: return w(62, 0); 4: return w(2, 20);
                   default: return 0;
               endcase
            default: return 0;
        endcase
    endfunction

    // one model step for the cycle whose inputs are currently driven
    task automatic model_step();
        int c, ins, op, opd, st_a, st_v;
        bit st;
        st = 1'b0; st_a = 0; st_v = 0;
        e_valid = run;
        e_exec = 1'b0;
        pc_tag = "R4"; acc_tag = "R4";
        if (run) begin
            c = mrot;
            e_ctx = c;
            e_pc = mpc[c];
            if (mh[c]) begin
                pc_tag = "R9"; acc_tag = "R9";
            end else begin
                e_exec = 1'b1;
                ins = mm[c][mpc[c]];
                op = ins >> 6;
                opd = ins & 63;
                mpc[c] = (mpc[c] + 1) % DEPTH;
                case (op)
                    0: begin mh[c] = 1'b1; mpc[c] = e_pc; pc_tag = "R9"; end
                    1: begin macc[c] = opd; acc_tag = "R5"; end
                    2: begin macc[c] = mm[c][opd]; acc_tag = "R5"; end
                    3: begin macc[c] = (macc[c] + opd) & AMASK; acc_tag = "R6"; end
                    4: begin macc[c] = (macc[c] + mm[c][opd]) & AMASK; acc_tag = "R6"; end
                    5: begin st = 1'b1; st_a = opd; st_v = macc[c] & 12'hFFF; acc_tag = "R7"; end
                    6: begin if (macc[c] == 0) mpc[c] = opd; pc_tag = "R8"; end
                    default: pc_tag = "R11";
                endcase
            end
            e_acc = macc[c];
            mrot = (c + 1) % N;
            if (st) mm[c][st_a] = st_v;
        end
        if (dbg_we) mm[dbg_ctx][dbg_addr] = dbg_wdata;
    endtask

    task automatic compare();
        if (!e_valid) begin
            chk("R2", tr_valid, 0, "tr_valid while stopped");
        end else begin
            chk("R1", tr_valid, 1, "tr_valid");
            chk("R1", tr_ctx, e_ctx, "tr_ctx");
            chk("R9", tr_exec, e_exec, "tr_exec");
            chk(pc_tag, tr_pc, e_pc, "tr_pc");
            chk(acc_tag, tr_acc, e_acc, "tr_acc");
        end
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        #1;
        compare();
    endtask

    bit done = 1'b0;
    int injected = 0;

    initial begin
        for (int c = 0; c < N; c++) begin
            mpc[c] = 0; macc[c] = 0; mh[c] = 1'b0;
            for (int a = 0; a < DEPTH; a++) mm[c][a] = 0;
        end
        mrot = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R3", tr_valid, 0, "tr_valid after reset");

        // preload every word of every context with run low
        for (int c = 0; c < N; c++) begin
            for (int a = 0; a < DEPTH; a++) begin
                @(negedge clk);
                dbg_we = 1'b1; dbg_ctx = CW'(c); dbg_addr = AW'(a);
                dbg_wdata = 12'(prog(c, a));
                cycle();
            end
        end
        @(negedge clk);
        dbg_we = 1'b0;
        dbg_ctx = 4'd3; dbg_addr = 6'd1;
        #1;
        chk("R10", dbg_rdata, w(5, 20), "debug readback ctx3 word1");
        chk("R3", tr_valid, 0, "no slot consumed before run");

        // first slot after reset: context 0, address 0
        run = 1'b1;
        cycle();
        chk("R3", tr_ctx, 0, "first served context");
        chk("R3", tr_pc, 0, "first served address");

        for (int k = 1; k < 1500; k++) begin
            @(negedge clk);
            run = !(k >= 300 && k < 306);
            dbg_we = 1'b0;
            if (run && mrot == 3 && !mh[3] && mm[3][mpc[3]] == w(5, 20)
                && injected == 0) begin
                dbg_we = 1'b1; dbg_ctx = 4'd3; dbg_addr = 6'd20;
                dbg_wdata = 12'hABC;
                injected++;
            end
            cycle();
        end
        chk("R10", injected, 1, "collision injected");

        @(negedge clk);
        run = 1'b0;
        dbg_we = 1'b0;
        cycle();
        for (int c = 0; c < 6; c++) begin
            foreach (mpc[i]) if (i == 0) begin end
            for (int j = 0; j < 3; j++) begin
                int a;
                a = (j == 0) ? 20 : (j == 1) ? 50 : 42;
                @(negedge clk);
                dbg_ctx = CW'(c); dbg_addr = AW'(a);
                #1;
                chk((c == 3 && a == 20) ? "R10" : "R7", dbg_rdata, mm[c][a],
                    $sformatf("bank ctx%0d word%0d", c, a));
            end
        end
        chk("R10", mm[3][20], 12'hABC, "model collision word");
        chk("R9", mh[2], 1, "ctx2 halted in model");
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule